// File: doc/BRIEF.md
# Chained Pass-Through Register Files

This block models a column of per-cell register files placed between the pipeline stages of a striped reconfigurable datapath. Each stage owns a file of P registers, each B bits wide. On every clock, each register either keeps a value handed down from the same-numbered register one stage earlier, or takes the result of its own stage's logic. Values that no stage rewrites therefore move one stage down the chain per cycle without using any logic cell.

Each stage has one write port and two read ports. The forward read port can select any register and supplies the operand of the following stage. Register 0 has a fixed second read path. That path feeds the current stage's lateral bus and also serves as the value saved when the stage is swapped out. Register 0 can also be reloaded from a restore input. The first stage's upstream inputs are tied to zero. The number of stages S is a parameter.

Top module: `pass_reg_chain`

## Requirements
- R1: A synchronous active-high `rst` clears every register of every stage at the clock edge where it is sampled high.
- R2: When `wr_en[s]` is high, register number `wr_idx[s]` of stage s (plain binary, 0 to P-1) takes `wr_data[s]` at the next edge, unless R5 applies to it.
- R3: Every register that is not written locally takes, at the next edge, the value of the same-numbered register in stage s-1. In stage 0 it takes zero instead.
- R4: While `wr_en[s]` is low, the values on `wr_idx[s]` and `wr_data[s]` have no effect, and every register of stage s follows R3.
- R5: When `restore_stb[s]` is high, register 0 of stage s takes `restore_data[s]` at the next edge. This has priority over both the local write and the pass-through value.
- R6: A restore changes only register 0. A local write to another register of the same stage in the same cycle still takes effect.
- R7: `reg0_q[s]` always shows register 0 of stage s. This port is the lateral-bus and save path.
- R8: `fwd_q[s]` shows the register of stage s selected by `rd_idx[s]` in the same cycle, with no added latency.
- R9: A value written into register r of stage 0 appears in register r of stage k exactly k cycles after the write edge, as long as no stage overwrites it.
- R10: A local write into stage s leaves the registers of all other stages unaffected in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | S | Per-stage local write enable |
| wr_idx | input | S*IW | Per-stage write register index, IW = ceil(log2 P), at least 1 |
| wr_data | input | S*B | Per-stage local logic result |
| restore_stb | input | S | Per-stage restore strobe for register 0 |
| restore_data | input | S*B | Per-stage restore value |
| rd_idx | input | S*IW | Per-stage forward read register index |
| fwd_q | output | S*B | Per-stage forward read port, feeds the next stage's operand |
| reg0_q | output | S*B | Per-stage register 0, feeds the lateral bus and the save path |

## Verification
The chain is driven with isolated writes into single stages, idle cycles, writes with the enable low, and cycles where restore and write collide on register 0 or on different registers. Idle cycles show whether values shift by exactly one stage and whether zero enters at the head. Enable-low cycles separate a gated write from one that leaks through. The collision cycles tell the priority of restore apart from the independence of the write port. Every register of every stage is read back through the forward port by sweeping the read index, so any register that was disturbed or is out of step shows up at that edge.

// File: rtl/pass_chain_pkg.sv
package pass_chain_pkg;

  // index width for a file of p registers, never below one bit
  function automatic int idx_bits(input int p);
    return (p > 1) ? $clog2(p) : 1;
  endfunction

endpackage

// File: rtl/pass_slot.sv
// One B-bit register of a pass file: restore, then local write, then pass-through.
module pass_slot #(
  parameter int B = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_stb,
  input  logic [B-1:0] ld_data,
  input  logic         wr_hit,
  input  logic [B-1:0] wr_data,
  input  logic [B-1:0] up_d,
  output logic [B-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (ld_stb) q <= ld_data;
    else if (wr_hit) q <= wr_data;
    else             q <= up_d;
  end

endmodule

// File: rtl/pass_rd_mux.sv
// Forward read port: selects one register of the file by index.
module pass_rd_mux #(
  parameter int B  = 8,
  parameter int P  = 4,
  parameter int IW = 2
) (
  input  logic [P*B-1:0] regs,
  input  logic [IW-1:0]  sel,
  output logic [B-1:0]   dout
);

  always_comb begin
    dout = '0;
    for (int r = 0; r < P; r++) begin
      if (sel == IW'(r)) dout = regs[r*B +: B];
    end
  end

endmodule

// File: rtl/pass_file.sv
// One stage: P slots, a write decoder, the forward read mux and the fixed register-0 path.
module pass_file #(
  parameter int B  = 8,
  parameter int P  = 4,
  parameter int IW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [B-1:0]   wr_data,
  input  logic           restore_stb,
  input  logic [B-1:0]   restore_data,
  input  logic [IW-1:0]  rd_idx,
  input  logic [P*B-1:0] up_regs,
  output logic [P*B-1:0] regs,
  output logic [B-1:0]   fwd_q,
  output logic [B-1:0]   reg0_q
);

  for (genvar r = 0; r < P; r++) begin : g_slot
    logic hit;
    logic ld;
    assign hit = wr_en && (wr_idx == IW'(r));
    // only register 0 is reachable by the restore path
    if (r == 0) begin : g_ld
      assign ld = restore_stb;
    end else begin : g_no_ld
      assign ld = 1'b0;
    end

    pass_slot #(.B(B)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .ld_stb  (ld),
      .ld_data (restore_data),
      .wr_hit  (hit),
      .wr_data (wr_data),
      .up_d    (up_regs[r*B +: B]),
      .q       (regs[r*B +: B])
    );
  end

  pass_rd_mux #(.B(B), .P(P), .IW(IW)) u_fwd (
    .regs (regs),
    .sel  (rd_idx),
    .dout (fwd_q)
  );

  assign reg0_q = regs[B-1:0];

endmodule

// File: rtl/pass_reg_chain.sv
module pass_reg_chain
  import pass_chain_pkg::*;
#(
  parameter int S = 4,
  parameter int B = 8,
  parameter int P = 4,
  localparam int IW = idx_bits(P)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [S-1:0]   wr_en,
  input  logic [S*IW-1:0] wr_idx,
  input  logic [S*B-1:0] wr_data,
  input  logic [S-1:0]   restore_stb,
  input  logic [S*B-1:0] restore_data,
  input  logic [S*IW-1:0] rd_idx,
  output logic [S*B-1:0] fwd_q,
  output logic [S*B-1:0] reg0_q
);

  // link[s] holds the registers that stage s receives from upstream
  logic [S:0][P*B-1:0] link;
  assign link[0] = '0;

  for (genvar s = 0; s < S; s++) begin : g_stage
    pass_file #(.B(B), .P(P), .IW(IW)) u_file (
      .clk          (clk),
      .rst          (rst),
      .wr_en        (wr_en[s]),
      .wr_idx       (wr_idx[s*IW +: IW]),
      .wr_data      (wr_data[s*B +: B]),
      .restore_stb  (restore_stb[s]),
      .restore_data (restore_data[s*B +: B]),
      .rd_idx       (rd_idx[s*IW +: IW]),
      .up_regs      (link[s]),
      .regs         (link[s+1]),
      .fwd_q        (fwd_q[s*B +: B]),
      .reg0_q       (reg0_q[s*B +: B])
    );
  end

endmodule

// File: rtl/pass_reg_chain_chk.sv
module pass_reg_chain_chk #(
  parameter int S  = 4,
  parameter int B  = 8,
  parameter int P  = 4,
  parameter int IW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic [S-1:0]   wr_en,
  input logic [S*IW-1:0] wr_idx,
  input logic [S*B-1:0] wr_data,
  input logic [S-1:0]   restore_stb,
  input logic [S*B-1:0] restore_data,
  input logic [S*IW-1:0] rd_idx,
  input logic [S*B-1:0] fwd_q,
  input logic [S*B-1:0] reg0_q
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  for (genvar s = 0; s < S; s++) begin : g_chk
    // R1: the edge after a sampled reset leaves register 0 cleared
    always_ff @(posedge clk) begin
      if (rst_d) assert_reset_clear_R1: assert (reg0_q[s*B +: B] == '0);
    end

    // R5: restore wins over everything on register 0
    assert_restore_load_R5: assert property (@(posedge clk) disable iff (rst)
      restore_stb[s] |=> reg0_q[s*B +: B] == $past(restore_data[s*B +: B]));

    // R2: local write into register 0 when no restore
    assert_local_write_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_en[s] && wr_idx[s*IW +: IW] == '0 && !restore_stb[s])
      |=> reg0_q[s*B +: B] == $past(wr_data[s*B +: B]));

    // R3: untouched register 0 takes the upstream register 0, zero at the head
    if (s == 0) begin : g_head
      assert_pass_head_R3: assert property (@(posedge clk) disable iff (rst)
        (!restore_stb[s] && !(wr_en[s] && wr_idx[s*IW +: IW] == '0))
        |=> reg0_q[s*B +: B] == '0);
    end else begin : g_body
      assert_pass_body_R3: assert property (@(posedge clk) disable iff (rst)
        (!restore_stb[s] && !(wr_en[s] && wr_idx[s*IW +: IW] == '0))
        |=> reg0_q[s*B +: B] == $past(reg0_q[(s-1)*B +: B]));
    end

    // R8: forward port agrees with the fixed register-0 path when it selects 0
    assert_fwd_sel0_R8: assert property (@(posedge clk) disable iff (rst)
      (rd_idx[s*IW +: IW] == '0) |-> fwd_q[s*B +: B] == reg0_q[s*B +: B]);
  end

endmodule

bind pass_reg_chain pass_reg_chain_chk #(.S(S), .B(B), .P(P), .IW(IW)) u_chk (.*);

// File: tb/tb_pass_reg_chain.sv
module tb_pass_reg_chain;
  localparam int S = 4;
  localparam int B = 8;
  localparam int P = 4;
  localparam int IW = 2;
  localparam int CLK_P = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [S-1:0]    wr_en = '0;
  logic [S*IW-1:0] wr_idx = '0;
  logic [S*B-1:0]  wr_data = '0;
  logic [S-1:0]    restore_stb = '0;
  logic [S*B-1:0]  restore_data = '0;
  logic [S*IW-1:0] rd_idx = '0;
  logic [S*B-1:0]  fwd_q;
  logic [S*B-1:0]  reg0_q;

  pass_reg_chain #(.S(S), .B(B), .P(P)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int          s;
    int          r;
    logic [B-1:0] v;
    string       tag;
  } exp_t;

  exp_t         sb[$];
  logic [B-1:0] mdl [S][P];
  int           n_chk = 0;
  int           n_err = 0;

  // per-stage stimulus set by the sequence before each step
  logic         d_we [S];
  int           d_wi [S];
  logic [B-1:0] d_wd [S];
  logic         d_rs [S];
  logic [B-1:0] d_rd [S];

  task automatic clear_drive();
    for (int s = 0; s < S; s++) begin
      d_we[s] = 1'b0; d_wi[s] = 0; d_wd[s] = '0; d_rs[s] = 1'b0; d_rd[s] = '0;
    end
  endtask

  task automatic check(input string tag, input int s, input int r,
                       input logic [B-1:0] act, input logic [B-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s stage %0d reg %0d: actual %h expected %h", tag, s, r, act, exp);
    end
  endtask

  // monitor: sweeps the forward read index and pops expected items
  task automatic observe();
    for (int r = 0; r < P; r++) begin
      for (int s = 0; s < S; s++) rd_idx[s*IW +: IW] = IW'(r);
      #1;
      for (int s = 0; s < S; s++) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " R8 fwd"}, e.s, e.r, fwd_q[e.s*B +: B], e.v);
        if (r == 0) check("R7 reg0 path", e.s, 0, reg0_q[e.s*B +: B], e.v);
      end
    end
  endtask

  // driver: applies stimulus, computes expected state from the requirements, pushes it
  task automatic step(input string tag, input logic do_rst);
    logic [B-1:0] nxt [S][P];
    rst = do_rst;
    for (int s = 0; s < S; s++) begin
      wr_en[s] = d_we[s];
      wr_idx[s*IW +: IW] = IW'(d_wi[s]);
      wr_data[s*B +: B] = d_wd[s];
      restore_stb[s] = d_rs[s];
      restore_data[s*B +: B] = d_rd[s];
      for (int r = 0; r < P; r++) begin
        nxt[s][r] = (s == 0) ? '0 : mdl[s-1][r];          // R3
        if (d_we[s] && d_wi[s] == r) nxt[s][r] = d_wd[s];  // R2, R4
        if (r == 0 && d_rs[s]) nxt[s][r] = d_rd[s];        // R5, R6
        if (do_rst) nxt[s][r] = '0;                        // R1
      end
    end
    @(posedge clk);
    for (int s = 0; s < S; s++)
      for (int r = 0; r < P; r++) mdl[s][r] = nxt[s][r];
    for (int r = 0; r < P; r++)
      for (int s = 0; s < S; s++) begin
        exp_t e;
        e.s = s; e.r = r; e.v = mdl[s][r]; e.tag = tag;
        sb.push_back(e);
      end
    #1;
    observe();
    clear_drive();
  endtask

  initial begin
    #(CLK_P * 50000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int s = 0; s < S; s++)
      for (int r = 0; r < P; r++) mdl[s][r] = '0;
    clear_drive();
    step("R1 reset", 1'b1);
    step("R1 reset", 1'b1);

    // R2: local writes into two stages
    d_we[0] = 1'b1; d_wi[0] = 1; d_wd[0] = 8'hA5;
    d_we[2] = 1'b1; d_wi[2] = 3; d_wd[2] = 8'h3C;
    step("R2 write", 1'b0);

    // R3: idle cycles shift everything down, zero enters stage 0
    for (int i = 0; i < 3; i++) step("R3 shift", 1'b0);

    // fill some values then R4: index and data with enable low
    d_we[1] = 1'b1; d_wi[1] = 2; d_wd[1] = 8'h6E;
    d_we[3] = 1'b1; d_wi[3] = 0; d_wd[3] = 8'hD1;
    step("R2 write", 1'b0);
    d_wi[1] = 2; d_wd[1] = 8'hFF; d_wi[2] = 3; d_wd[2] = 8'hEE;
    step("R4 enable low", 1'b0);

    // R5: restore collides with a local write to register 0
    d_rs[1] = 1'b1; d_rd[1] = 8'h77;
    d_we[1] = 1'b1; d_wi[1] = 0; d_wd[1] = 8'h11;
    step("R5 restore priority", 1'b0);

    // R6: restore and a write to another register in the same stage
    d_rs[2] = 1'b1; d_rd[2] = 8'h42;
    d_we[2] = 1'b1; d_wi[2] = 2; d_wd[2] = 8'h99;
    step("R6 restore plus write", 1'b0);

    // R9: inject at stage 0 and watch it reach stage k after k cycles
    d_we[0] = 1'b1; d_wi[0] = 2; d_wd[0] = 8'hE1;
    step("R9 inject", 1'b0);
    for (int k = 1; k < S; k++) begin
      step("R9 travel", 1'b0);
      check("R9 arrival", k, 2, mdl[k][2], 8'hE1);
      rd_idx[k*IW +: IW] = 2'd2;
      #1;
      check("R9 arrival port", k, 2, fwd_q[k*B +: B], 8'hE1);
    end

    // R10: a write into stage 1 alone
    d_we[1] = 1'b1; d_wi[1] = 1; d_wd[1] = 8'h5A;
    step("R10 isolated write", 1'b0);
    step("R10 follow", 1'b0);

    // R1: reset in the middle of traffic
    d_we[3] = 1'b1; d_wi[3] = 3; d_wd[3] = 8'hC3;
    step("R2 write", 1'b0);
    step("R1 reset mid-run", 1'b1);
    step("R3 after reset", 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule